// File: doc/BRIEF.md
# USB Packet Error Tracker

This block sits beside a USB serial interface engine and consumes its per-packet error flags. It never computes a CRC or checks a PID. At the end of each received packet the engine raises `pkt_end` for one cycle and presents three flags: bit-stuff violation, PID check failure and CRC mismatch. The flags are ignored in any cycle where `pkt_end` is low. From these flags the block keeps one saturating counter and one sticky status bit per error type. It raises an interrupt when an enabled status bit is set.

The block also decides what happens to each packet. A packet that carries any error is discarded: a one-cycle `pkt_drop` pulse tells the buffer logic not to commit it. A data packet is also discarded when the token before it was damaged. A handshake is granted with a one-cycle `hs_ack` pulse only when a clean data packet follows a clean token. There is no data stream through the block, so every pin is a plain control or status signal with no back-pressure. The register port is a single-cycle write strobe with a combinational read path selected by `reg_addr`.

Top module: `usb_err_tracker`

## Requirements
- R1: After reset, all counters, status bits and enable bits read zero, and `irq`, `hs_ack` and `pkt_drop` are low.
- R2: Each error flag seen with `pkt_end` adds one to its own counter on the next clock edge. Counter layout at `reg_addr`=0: bit-stuff in bits [7:0], PID in [15:8], CRC in [23:16]; bits [31:24] read zero.
- R3: A counter at 255 stays at 255 when further errors of its type arrive.
- R4: Any write to address 0 clears all three counters. If a flag arrives in the same cycle, its counter becomes 1 rather than 0.
- R5: Each error flag with `pkt_end` sets its status bit at `reg_addr`=1 (bit 0 bit-stuff, bit 1 PID, bit 2 CRC). A write to address 1 clears only the status bits written as one.
- R6: When an error and a write-one-to-clear of the same status bit occur in one cycle, the bit ends up set.
- R7: The enable register at `reg_addr`=2 is read/write in bits [2:0], using the same bit order as status. `irq` is high exactly when some status bit and its enable bit are both set. Address 3 reads zero.
- R8: `pkt_drop` pulses for one cycle after either of two packets: one that carries any error, or a data packet whose most recent token carried an error.
- R9: `hs_ack` pulses for one cycle after a data packet without errors whose most recent token was also without errors. It is never high together with `pkt_drop`.
- R10: When `pkt_end` is low, the error flags change no counter, status bit or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_end | input | 1 | One-cycle strobe marking the end of a received packet |
| pkt_is_data | input | 1 | 1 = data packet, 0 = token packet (valid with `pkt_end`) |
| err_stuff | input | 1 | Bit-stuff violation flag for the ending packet |
| err_pid | input | 1 | PID check failure flag for the ending packet |
| err_crc | input | 1 | CRC mismatch flag for the ending packet |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 counters, 1 status, 2 enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Interrupt, set when an enabled status bit is set |
| hs_ack | output | 1 | Handshake grant pulse |
| pkt_drop | output | 1 | Discard pulse for the previous packet |

## Verification
A wrong counter, status bit or token flag becomes visible at the ports within one clock. It shows up either in `reg_rdata` while that register is selected, or in `irq`, `hs_ack` and `pkt_drop` one cycle after the packet that should have changed it. The bench therefore keeps a behavioural model of the counters, status bits, enables and last-token state, and compares every output a quarter period after each rising edge. A stale token flag shows up only on the next data packet, so the stimulus follows bad tokens with data packets. A counter that wraps shows up as a small value after the 256th error, so the stimulus drives well past 255 errors of one type.

// File: rtl/usb_err_pkg.sv
package usb_err_pkg;
  localparam int NUM_ERR   = 3;
  localparam int ERR_STUFF = 0;
  localparam int ERR_PID   = 1;
  localparam int ERR_CRC   = 2;

  typedef enum logic [1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_STATUS = 2'd1,
    ADDR_ENABLE = 2'd2,
    ADDR_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usb_err_counter.sv
module usb_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (inc && clr)     cnt <= CNT_W'(1);
    else if (inc)            cnt <= (cnt == CNT_MAX) ? CNT_MAX : cnt + CNT_W'(1);
    else if (clr)            cnt <= '0;
  end

  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt - $past(cnt)) <= CNT_W'(1));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> cnt == '0);
endmodule

// File: rtl/usb_err_status.sv
module usb_err_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] st
);
  logic [N-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr_eff) | set;
  end

  // R6: a set always survives a simultaneous clear
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((st & $past(set)) == $past(set)));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(|set)) |=> ((st & $past(clr_mask)) == '0));
endmodule

// File: rtl/usb_err_hsgate.sv
module usb_err_hsgate (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_end,
  input  logic pkt_is_data,
  input  logic pkt_err,
  output logic hs_ack,
  output logic pkt_drop
);
  logic tok_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_bad  <= 1'b0;
      hs_ack   <= 1'b0;
      pkt_drop <= 1'b0;
    end else begin
      hs_ack   <= pkt_end && pkt_is_data && !pkt_err && !tok_bad;
      pkt_drop <= pkt_end && (pkt_err || (pkt_is_data && tok_bad));
      if (pkt_end && !pkt_is_data) tok_bad <= pkt_err;
    end
  end

  assert_ack_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> $past(pkt_end && pkt_is_data && !pkt_err));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_ack && pkt_drop));

  assert_drop_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && pkt_err) |=> pkt_drop);
endmodule

// File: rtl/usb_err_tracker.sv
module usb_err_tracker
  import usb_err_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_end,
  input  logic              pkt_is_data,
  input  logic              err_stuff,
  input  logic              err_pid,
  input  logic              err_crc,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              hs_ack,
  output logic              pkt_drop
);
  localparam int CNT_BITS = NUM_ERR * CNT_W;

  logic [NUM_ERR-1:0]  err_raw, err_hit, status, enable;
  logic [CNT_BITS-1:0] cnt_flat;
  logic                wr_count, wr_status, wr_enable;
  logic                unused_wdata;

  assign err_raw[ERR_STUFF] = err_stuff;
  assign err_raw[ERR_PID]   = err_pid;
  assign err_raw[ERR_CRC]   = err_crc;
  assign err_hit   = pkt_end ? err_raw : '0;
  assign wr_count  = reg_wr && (reg_addr == ADDR_COUNT);
  assign wr_status = reg_wr && (reg_addr == ADDR_STATUS);
  assign wr_enable = reg_wr && (reg_addr == ADDR_ENABLE);
  assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_ERR];

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_cnt
    usb_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_count),
      .inc   (err_hit[i]),
      .cnt   (cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  usb_err_status #(.N(NUM_ERR)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (err_hit),
    .clr_en   (wr_status),
    .clr_mask (reg_wdata[NUM_ERR-1:0]),
    .st       (status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         enable <= '0;
    else if (wr_enable) enable <= reg_wdata[NUM_ERR-1:0];
  end

  assign irq = |(status & enable);

  usb_err_hsgate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_end     (pkt_end),
    .pkt_is_data (pkt_is_data),
    .pkt_err     (|err_hit),
    .hs_ack      (hs_ack),
    .pkt_drop    (pkt_drop)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_COUNT:  reg_rdata[CNT_BITS-1:0] = cnt_flat;
      ADDR_STATUS: reg_rdata[NUM_ERR-1:0]  = status;
      ADDR_ENABLE: reg_rdata[NUM_ERR-1:0]  = enable;
      default:     reg_rdata = '0;
    endcase
  end

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && reg_wdata[NUM_ERR-1:0] == '0) |=> !irq);

  assert_idle_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_end && !reg_wr) |=> ($stable(status) && !hs_ack && !pkt_drop));
endmodule

// File: tb/test_usb_err_tracker.sv
module test_usb_err_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_end = 1'b0, pkt_is_data = 1'b0;
  logic err_stuff = 1'b0, err_pid = 1'b0, err_crc = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, hs_ack, pkt_drop;

  int checks = 0;
  int errors = 0;
  int m_cnt [3];
  logic [2:0] m_st = '0, m_en = '0;
  logic m_tok = 1'b0, m_ack = 1'b0, m_drop = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_err_tracker i_usb_err_tracker (
    .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .pkt_is_data(pkt_is_data),
    .err_stuff(err_stuff), .err_pid(err_pid), .err_crc(err_crc),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .hs_ack(hs_ack), .pkt_drop(pkt_drop)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    logic [2:0] ev;
    logic any;
    logic [31:0] exp_rd;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
      m_st = '0; m_en = '0; m_tok = 0; m_ack = 0; m_drop = 0;
    end else begin
      ev = pkt_end ? {err_crc, err_pid, err_stuff} : 3'b000; // R10
      any = |ev;
      for (int i = 0; i < 3; i++) begin
        if (reg_wr && reg_addr == 2'd0) m_cnt[i] = ev[i] ? 1 : 0;
        else if (ev[i]) m_cnt[i] = (m_cnt[i] >= 255) ? 255 : m_cnt[i] + 1;
      end
      m_st = (m_st & ~((reg_wr && reg_addr == 2'd1) ? reg_wdata[2:0] : 3'b000)) | ev;
      if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata[2:0];
      m_ack  = pkt_end && pkt_is_data && !any && !m_tok;
      m_drop = pkt_end && (any || (pkt_is_data && m_tok));
      if (pkt_end && !pkt_is_data) m_tok = any;
    end
    #(CLK_PERIOD/4);
    if (!done) begin
      case (reg_addr)
        2'd0: exp_rd = {8'h00, 8'(m_cnt[2]), 8'(m_cnt[1]), 8'(m_cnt[0])};
        2'd1: exp_rd = {29'd0, m_st};
        2'd2: exp_rd = {29'd0, m_en};
        default: exp_rd = '0;
      endcase
      if (!rst_n) check("R1 rdata", reg_rdata, 32'd0);
      else case (reg_addr)
        2'd0: check("R2 R3 R4 R10 count", reg_rdata, exp_rd);
        2'd1: check("R5 R6 status", reg_rdata, exp_rd);
        default: check("R7 enable/none", reg_rdata, exp_rd);
      endcase
      check("R7 irq", {31'd0, irq}, {31'd0, |(m_st & m_en)});
      check("R9 hs_ack", {31'd0, hs_ack}, {31'd0, m_ack});
      check("R8 pkt_drop", {31'd0, pkt_drop}, {31'd0, m_drop});
    end
  end

  task automatic cyc(logic pe, logic kind, logic s, logic p, logic c,
                     logic we, logic [1:0] a, logic [31:0] wd);
    @(negedge clk);
    pkt_end = pe; pkt_is_data = kind; err_stuff = s; err_pid = p; err_crc = c;
    reg_wr = we; reg_addr = a; reg_wdata = wd;
  endtask

  task automatic idle(logic [1:0] a);
    cyc(0, 0, 0, 0, 0, 0, a, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) idle(0);
    @(negedge clk); rst_n = 1'b1;
    idle(1); idle(2); idle(0);
    // R2 bit-stuff error on a token, then R8 data after bad token
    cyc(1, 0, 1, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    // R9 clean token then clean data
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    idle(0);
    // R2 multiple flags in one data packet
    cyc(1, 1, 0, 1, 1, 0, 0, 0);
    // R10 flags without pkt_end
    cyc(0, 1, 1, 1, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 1, 0, 1, 0);
    idle(1);
    // R7 enable PID only, then mask
    cyc(0, 0, 0, 0, 0, 1, 2, 32'hFFFF_FFFA);
    idle(2);
    cyc(0, 0, 0, 0, 0, 1, 2, 32'h0000_0000);
    idle(3);
    cyc(0, 0, 0, 0, 0, 1, 2, 32'h0000_0007);
    // R5 clear only the PID bit
    cyc(0, 0, 0, 0, 0, 1, 1, 32'h0000_0002);
    idle(1);
    // R6 clear CRC while a CRC error arrives
    cyc(1, 1, 0, 0, 1, 1, 1, 32'h0000_0007);
    idle(1);
    // R3 drive CRC counter past saturation
    for (int k = 0; k < 300; k++) cyc(1, 1, 0, 0, 1, 0, 0, 0);
    idle(0);
    // R4 clear counters, then clear with a simultaneous stuff error
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0);
    idle(0);
    for (int k = 0; k < 5; k++) cyc(1, 0, 0, 1, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0, 1, 0, 32'h0);
    idle(0);
    // R8 bad token followed by a clean data packet, then recovery R9
    cyc(1, 0, 0, 0, 1, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    idle(1); idle(2); idle(3);
    // R1 re-apply reset mid-run
    @(negedge clk); rst_n = 1'b0;
    idle(0); idle(0);
    @(negedge clk); rst_n = 1'b1;
    idle(1); idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule